// File: doc/BRIEF.md
# Memory Power Mode Controller

This controller picks the operating mode of a memory power subsystem built from a main switching buck, a tracking termination regulator and a secondary switching buck. There are three modes: run, sleep and shutdown. Its inputs are the digital good flags of the supply monitors, a sleep-request line from the platform and an in-regulation flag from the main buck. It wakes the supply monitors in a fixed order. It then starts the main rail's soft-start. Once the main rail is up, it releases the termination regulator and the secondary buck.

The controller also sets a per-mode state for each regulator and gate-drive group. In sleep mode the main buck runs in standby at double switching frequency. The termination output is released to high impedance and the secondary buck is stopped. In shutdown every gate drive is held low.

Each asynchronous input passes through a two-flop synchronizer. The soft-start interval is a cycle counter whose length is set by the `SS_CYCLES` parameter.

Top module: `mem_pwr_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it is released, `mode_o` is 2'b00 (shutdown), both monitor enables are low and every rail, gate and enable output is in its shutdown value.
- R2: `aux_mon_en_o` follows the synchronized reference-good flag. `boot_mon_en_o` is high only while both the reference-good and auxiliary-good flags are high. A boot-good flag alone never starts sequencing.
- R3: From shutdown (2'b00) the block enters run (2'b01) only when the reference, auxiliary and boot flags are all good and the synchronized sleep request is low. On entry `main_ss_o` is high.
- R4: In run mode, `term_en_o`, `sec_en_o` and secondary gate state 2'b01 are given only while the in-regulation flag is high and the soft-start count is complete. The count completes exactly `SS_CYCLES` clock edges after run mode is entered, and `main_ss_o` falls at the same point.
- R5: In run mode, a low-to-high transition of the synchronized sleep request moves the block to sleep (2'b10). While asleep, a low sleep request returns it to run.
- R6: In run mode, the loss of any of the reference, auxiliary or boot flags moves the block to shutdown. This takes priority over a sleep-request edge in the same cycle.
- R7: Sleep never moves directly to shutdown, and shutdown never moves directly to sleep. Supply loss while asleep leaves the block asleep.
- R8: In run mode, `main_rail_o` and `main_gate_o` are 2'b01 (normal) and `term_oe_o` is high.
- R9: In sleep mode, `main_rail_o` and `main_gate_o` are 2'b10 (standby), `term_oe_o` and `term_en_o` are low, `sec_en_o` is low and `sec_gate_o` is 2'b00 (forced low).
- R10: In shutdown, `main_rail_o` is 2'b00 (off), `main_gate_o` and `sec_gate_o` are 2'b00, and `term_oe_o`, `term_en_o`, `sec_en_o`, `main_ss_o` are low.
- R11: `freq_dbl_o` is high exactly while the block is in sleep mode.
- R12: A change on any asynchronous input reaches the mode state on the third rising clock edge after it is applied, not before.
- R13: The soft-start count clears whenever the block leaves run mode. Each re-entry into run waits a full `SS_CYCLES` edges before the enables of R4 return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Sleep request, asynchronous |
| ref_good_i | input | 1 | Reference-good flag, asynchronous |
| aux_good_i | input | 1 | Auxiliary 5 V rail good, asynchronous |
| boot_good_i | input | 1 | Boot rail good, asynchronous |
| main_inreg_i | input | 1 | Main buck in regulation, asynchronous |
| mode_o | output | 2 | Mode: 00 shutdown, 01 run, 10 sleep |
| aux_mon_en_o | output | 1 | Auxiliary-rail monitor enable |
| boot_mon_en_o | output | 1 | Boot-rail monitor enable |
| main_ss_o | output | 1 | Main buck soft-start active |
| main_rail_o | output | 2 | Main buck state: 00 off, 01 normal, 10 standby |
| main_gate_o | output | 2 | Main gate drives: 00 low, 01 switching, 10 standby |
| term_en_o | output | 1 | Termination regulator enable |
| term_oe_o | output | 1 | Termination output drive (low means high impedance) |
| sec_en_o | output | 1 | Secondary buck enable |
| sec_gate_o | output | 2 | Secondary gate drives: 00 low, 01 switching |
| freq_dbl_o | output | 1 | Main buck switching-frequency double select |

## Verification
The assertions check the following on every cycle:
- the mode graph: no sleep-to-shutdown or shutdown-to-sleep step, and no illegal code;
- the monitor ordering;
- that the secondary buck is enabled only in run mode after soft-start;
- the shutdown drive values;
- that the frequency-double select tracks sleep.

Only the bench scenarios can show the following:
- the exact three-edge synchronizer latency;
- the exact soft-start length and its restart after a sleep round trip;
- loss-over-sleep priority;
- that supply loss during sleep takes effect only once the block has returned to run.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_RUN   = 2'b01,
    MODE_SLEEP = 2'b10
  } pwr_mode_e;

  typedef enum logic [1:0] {
    RAIL_OFF  = 2'b00,
    RAIL_NORM = 2'b01,
    RAIL_STBY = 2'b10
  } rail_e;

  typedef enum logic [1:0] {
    GATE_LOW  = 2'b00,
    GATE_SW   = 2'b01,
    GATE_STBY = 2'b10
  } gate_e;

  localparam int unsigned N_ASYNC = 5;
  localparam int unsigned IDX_SLEEP = 0;
  localparam int unsigned IDX_REF   = 1;
  localparam int unsigned IDX_AUX   = 2;
  localparam int unsigned IDX_BOOT  = 3;
  localparam int unsigned IDX_INREG = 4;
endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/pms_ss_timer.sv
module pms_ss_timer #(
  parameter int unsigned SS_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(SS_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(SS_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!run_i)                   cnt_q <= '0;
    else if (cnt_q != CNT_MAX)         cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/pms_out_dec.sv
module pms_out_dec
  import pms_pkg::*;
(
  input  pwr_mode_e mode_i,
  input  logic      ss_done_i,
  input  logic      inreg_i,
  output logic      main_ss_o,
  output logic [1:0] main_rail_o,
  output logic [1:0] main_gate_o,
  output logic      term_en_o,
  output logic      term_oe_o,
  output logic      sec_en_o,
  output logic [1:0] sec_gate_o,
  output logic      freq_dbl_o
);
  logic pgood;
  assign pgood = ss_done_i & inreg_i;

  always_comb begin
    main_ss_o   = 1'b0;
    main_rail_o = RAIL_OFF;
    main_gate_o = GATE_LOW;
    term_en_o   = 1'b0;
    term_oe_o   = 1'b0;
    sec_en_o    = 1'b0;
    sec_gate_o  = GATE_LOW;
    freq_dbl_o  = 1'b0;
    unique case (mode_i)
      MODE_RUN: begin
        main_ss_o   = ~ss_done_i;
        main_rail_o = RAIL_NORM;
        main_gate_o = GATE_SW;
        term_oe_o   = 1'b1;
        term_en_o   = pgood;
        sec_en_o    = pgood;
        sec_gate_o  = pgood ? GATE_SW : GATE_LOW;
      end
      MODE_SLEEP: begin
        main_rail_o = RAIL_STBY;
        main_gate_o = GATE_STBY;
        freq_dbl_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mem_pwr_mode_ctrl.sv
module mem_pwr_mode_ctrl
  import pms_pkg::*;
#(
  parameter int unsigned SS_CYCLES   = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       ref_good_i,
  input  logic       aux_good_i,
  input  logic       boot_good_i,
  input  logic       main_inreg_i,
  output logic [1:0] mode_o,
  output logic       aux_mon_en_o,
  output logic       boot_mon_en_o,
  output logic       main_ss_o,
  output logic [1:0] main_rail_o,
  output logic [1:0] main_gate_o,
  output logic       term_en_o,
  output logic       term_oe_o,
  output logic       sec_en_o,
  output logic [1:0] sec_gate_o,
  output logic       freq_dbl_o
);
  logic [N_ASYNC-1:0] async_raw, async_s;
  logic sleep_s, ref_s, aux_s, boot_s, inreg_s;
  logic sleep_q, sleep_rise, supplies_ok, ss_done;
  pwr_mode_e mode_q, mode_d;

  assign async_raw[IDX_SLEEP] = sleep_req_i;
  assign async_raw[IDX_REF]   = ref_good_i;
  assign async_raw[IDX_AUX]   = aux_good_i;
  assign async_raw[IDX_BOOT]  = boot_good_i;
  assign async_raw[IDX_INREG] = main_inreg_i;

  pms_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_raw),
    .q_o   (async_s)
  );

  assign sleep_s = async_s[IDX_SLEEP];
  assign ref_s   = async_s[IDX_REF];
  assign aux_s   = async_s[IDX_AUX];
  assign boot_s  = async_s[IDX_BOOT];
  assign inreg_s = async_s[IDX_INREG];

  // monitor wake-up chain: reference, then aux, then boot
  assign aux_mon_en_o  = ref_s;
  assign boot_mon_en_o = ref_s & aux_s;
  assign supplies_ok   = boot_mon_en_o & boot_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sleep_q <= 1'b0;
    else         sleep_q <= sleep_s;
  end
  assign sleep_rise = sleep_s & ~sleep_q;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_OFF:   if (supplies_ok && !sleep_s) mode_d = MODE_RUN;
      MODE_RUN: begin
        if (!supplies_ok)    mode_d = MODE_OFF;
        else if (sleep_rise) mode_d = MODE_SLEEP;
      end
      MODE_SLEEP: if (!sleep_s) mode_d = MODE_RUN;
      default:    mode_d = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else         mode_q <= mode_d;
  end

  pms_ss_timer #(.SS_CYCLES(SS_CYCLES)) u_ss (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (mode_q == MODE_RUN),
    .done_o(ss_done)
  );

  pms_out_dec u_dec (
    .mode_i     (mode_q),
    .ss_done_i  (ss_done),
    .inreg_i    (inreg_s),
    .main_ss_o  (main_ss_o),
    .main_rail_o(main_rail_o),
    .main_gate_o(main_gate_o),
    .term_en_o  (term_en_o),
    .term_oe_o  (term_oe_o),
    .sec_en_o   (sec_en_o),
    .sec_gate_o (sec_gate_o),
    .freq_dbl_o (freq_dbl_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/pms_chk.sv
module pms_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_o,
  input logic       aux_mon_en_o,
  input logic       boot_mon_en_o,
  input logic       main_ss_o,
  input logic [1:0] main_gate_o,
  input logic       term_en_o,
  input logic       term_oe_o,
  input logic       sec_en_o,
  input logic [1:0] sec_gate_o,
  input logic       freq_dbl_o
);
  p_legal_mode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  p_boot_after_aux_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_mon_en_o |-> aux_mon_en_o);

  p_ss_on_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00) |=> (mode_o != 2'b01 || main_ss_o));

  p_sec_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_en_o |-> (mode_o == 2'b01 && !main_ss_o && term_en_o));

  p_no_sleep_to_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10) |=> (mode_o != 2'b00));

  p_no_off_to_sleep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00) |=> (mode_o != 2'b10));

  p_sleep_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10) |-> (!term_oe_o && !sec_en_o && sec_gate_o == 2'b00));

  p_off_drive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00) |-> (main_gate_o == 2'b00 && sec_gate_o == 2'b00 && !term_oe_o && !term_en_o));

  p_freq_dbl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_dbl_o == (mode_o == 2'b10));
endmodule

bind mem_pwr_mode_ctrl pms_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_o       (mode_o),
  .aux_mon_en_o (aux_mon_en_o),
  .boot_mon_en_o(boot_mon_en_o),
  .main_ss_o    (main_ss_o),
  .main_gate_o  (main_gate_o),
  .term_en_o    (term_en_o),
  .term_oe_o    (term_oe_o),
  .sec_en_o     (sec_en_o),
  .sec_gate_o   (sec_gate_o),
  .freq_dbl_o   (freq_dbl_o)
);

// File: tb/mem_pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module mem_pwr_mode_ctrl_test;
  localparam int SS = 8;
  localparam int M_OFF = 0, M_RUN = 1, M_SLP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slp = 0, rg = 0, ag = 0, bg = 0, ir = 0;
  logic [1:0] mode, main_rail, main_gate, sec_gate;
  logic aux_mon, boot_mon, main_ss, term_en, term_oe, sec_en, fdbl;
  int checks = 0, errs = 0;

  always #4 clk = ~clk;

  mem_pwr_mode_ctrl #(.SS_CYCLES(SS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(slp), .ref_good_i(rg),
    .aux_good_i(ag), .boot_good_i(bg), .main_inreg_i(ir),
    .mode_o(mode), .aux_mon_en_o(aux_mon), .boot_mon_en_o(boot_mon),
    .main_ss_o(main_ss), .main_rail_o(main_rail), .main_gate_o(main_gate),
    .term_en_o(term_en), .term_oe_o(term_oe), .sec_en_o(sec_en),
    .sec_gate_o(sec_gate), .freq_dbl_o(fdbl)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int next_mode(int m, bit sup, bit s, bit rise);
    case (m)
      M_OFF:   return (sup && !s) ? M_RUN : M_OFF;
      M_RUN:   return !sup ? M_OFF : (rise ? M_SLP : M_RUN);
      default: return !s ? M_RUN : M_SLP;
    endcase
  endfunction

  // expected drive values by mode; pg = soft-start done and in regulation
  task automatic check_all(string req, int em, bit pg, bit ss_act);
    chk(req, "mode", mode, em);
    chk("R2", "aux_mon", aux_mon, rg);
    chk("R2", "boot_mon", boot_mon, rg & ag);
    chk("R11", "freq_dbl", fdbl, em == M_SLP);
    case (em)
      M_RUN: begin
        chk("R8", "main_rail", main_rail, 1);
        chk("R8", "main_gate", main_gate, 1);
        chk("R8", "term_oe", term_oe, 1);
        chk("R4", "term_en", term_en, pg);
        chk("R4", "sec_en", sec_en, pg);
        chk("R4", "sec_gate", sec_gate, pg ? 1 : 0);
        chk("R4", "main_ss", main_ss, ss_act);
      end
      M_SLP: begin
        chk("R9", "main_rail", main_rail, 2);
        chk("R9", "main_gate", main_gate, 2);
        chk("R9", "term_oe", term_oe, 0);
        chk("R9", "term_en", term_en, 0);
        chk("R9", "sec_en", sec_en, 0);
        chk("R9", "sec_gate", sec_gate, 0);
        chk("R9", "main_ss", main_ss, 0);
      end
      default: begin
        chk("R10", "main_rail", main_rail, 0);
        chk("R10", "main_gate", main_gate, 0);
        chk("R10", "term_oe", term_oe, 0);
        chk("R10", "term_en", term_en, 0);
        chk("R10", "sec_en", sec_en, 0);
        chk("R10", "sec_gate", sec_gate, 0);
        chk("R10", "main_ss", main_ss, 0);
      end
    endcase
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int em;
    bit ps;
    void'($urandom(32'h5EED_0042));
    step(2);
    check_all("R1", M_OFF, 0, 0);          // R1 during reset
    rst_n = 1'b1;
    step(4);
    check_all("R1", M_OFF, 0, 0);

    // R2: boot good alone does nothing; monitors wake in order
    bg = 1; ir = 1;
    step(4);
    check_all("R2", M_OFF, 0, 0);
    rg = 1;
    step(4);
    check_all("R2", M_OFF, 0, 0);

    // R12 latency and R3 entry
    ag = 1;
    step(2);
    chk("R12", "mode before 3rd edge", mode, M_OFF);
    step(1);
    check_all("R3", M_RUN, 0, 1);
    // R4 exact soft-start length
    step(SS - 1);
    chk("R4", "sec_en before count done", sec_en, 0);
    chk("R4", "main_ss before count done", main_ss, 1);
    step(1);
    check_all("R4", M_RUN, 1, 0);
    ir = 0;
    step(3);
    check_all("R4", M_RUN, 0, 0);
    ir = 1;
    step(3);
    check_all("R8", M_RUN, 1, 0);

    // R5 sleep entry, R7 supply loss in sleep ignored
    slp = 1;
    step(3);
    check_all("R5", M_SLP, 0, 0);
    ag = 0; bg = 0;
    step(8);
    chk("R7", "mode after loss in sleep", mode, M_SLP);
    slp = 0;
    step(3);
    chk("R7", "sleep release goes to run first", mode, M_RUN);
    step(1);
    check_all("R6", M_OFF, 0, 0);

    // R3/R7: sleep high in shutdown blocks run and never gives sleep
    ag = 1; bg = 1; slp = 1;
    step(8);
    check_all("R7", M_OFF, 0, 0);
    slp = 0;
    step(3);
    check_all("R3", M_RUN, 0, 1);
    step(SS + 2);
    check_all("R8", M_RUN, 1, 0);

    // R13 soft-start restarts after sleep round trip
    slp = 1;
    step(3);
    check_all("R5", M_SLP, 0, 0);
    slp = 0;
    step(3);
    check_all("R13", M_RUN, 0, 1);
    step(SS - 1);
    chk("R13", "sec_en before restart done", sec_en, 0);
    step(1);
    chk("R13", "sec_en after restart", sec_en, 1);

    // R6 loss priority over simultaneous sleep edge
    rg = 0; slp = 1;
    step(3);
    check_all("R6", M_OFF, 0, 0);

    // constrained random against bench model
    em = M_OFF;
    ps = slp;
    for (int i = 0; i < 200; i++) begin
      bit sup, rise;
      rg  = ($urandom % 8) != 0;
      ag  = ($urandom % 8) != 0;
      bg  = ($urandom % 8) != 0;
      ir  = ($urandom % 6) != 0;
      slp = ($urandom % 3) == 0;
      sup = rg & ag & bg;
      rise = slp & ~ps;
      em = next_mode(em, sup, slp, rise);
      for (int k = 0; k < 3; k++) em = next_mode(em, sup, slp, 1'b0);
      ps = slp;
      step(24);
      check_all("R5", em, (em == M_RUN) && ir, 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule